// File: doc/BRIEF.md
# LPC Memory Read Target

This block is a target on the Low Pin Count bus that answers single-byte memory reads. It runs on the bus clock. It watches the active-low frame strobe and the 4-bit multiplexed LAD lines, and it drives LAD back through a separate output value and output enable. A host cycle opens with a start nibble while the strobe is low. The next clock carries a cycle-type nibble, and the eight clocks after that carry a 32-bit address, most-significant nibble first. The host then spends one clock on turnaround.

After the host turnaround the target takes over LAD. It drives all ones for one clock, then a zero sync nibble, then the data byte low nibble first, then all ones again. On the last clock it releases the bus. The byte comes from an external synchronous byte-array read port: the target presents the byte address with a read enable during the host turnaround clock and captures the returned byte one clock later. Only the low address bits that fit the array are used.

Any clock with the frame strobe low restarts start detection and cancels whatever the target was doing. A start nibble other than zero, or a cycle type that is not a memory read, sends the target back to idle without ever driving the bus.

Top module: `lpc_read_target`

## Requirements
- R1: While reset is asserted and on the first clocks after it, the LAD output enable is low and no memory read is requested.
- R2: A cycle starts only on a clock where the frame strobe is low and LAD is 0000b. When the strobe stays low for several clocks, only the nibble on the last low clock counts.
- R3: The clock after the start carries the cycle type. Bits 3:2 must be 01b and bit 1 must be 0 (memory read). Bit 0 has no effect: 0100b and 0101b both give a full read.
- R4: The next eight clocks shift in a 32-bit address, most-significant nibble first. During the host turnaround clock that follows, the read enable is high and the byte address equals address bits 18:0. Bits 31:19 are ignored.
- R5: On clock 12 of the frame (counting the start as clock 1), the target enables its LAD output and drives 1111b.
- R6: On clock 13 the target drives the sync value 0000b.
- R7: On clock 14 the target drives data bits 3:0, and on clock 15 it drives data bits 7:4 of the byte stored at the selected address.
- R8: On clock 16 the target drives 1111b. From clock 17 on, the output enable is low.
- R9: A start nibble other than 0000b, or a cycle type that is not a memory read (for example 0110b, 1100b or 0000b), leaves the target idle. The output enable stays low until the next valid start.
- R10: The output enable is high only on clocks 12 to 16 of an accepted read, and low at every other time.
- R11: A clock with the frame strobe low, at any point of a cycle, cancels it. The output enable is low on the following clock. If that clock carries 0000b, a new cycle starts there.
- R12: Asserting the active-low reset in the middle of a cycle releases the bus at once and returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all fields are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| ladIn | input | 4 | LAD value seen on the bus |
| ladOut | output | 4 | LAD value driven by the target |
| ladOe | output | 1 | LAD output enable; high only while the target owns the bus |
| memRdEn | output | 1 | Read request to the byte array, high for the host turnaround clock |
| memAddr | output | 19 | Byte address to the array |
| memData | input | 8 | Byte returned by the array one clock after the read request |

## Verification
Every result has a fixed distance from the start clock. The read request and byte address appear after the tenth rising edge. The all-ones turnaround drive follows the eleventh edge, the sync value the twelfth, and the two data nibbles the thirteenth and fourteenth. The closing all-ones drive follows the fifteenth edge, and the release follows the sixteenth. A cancelling strobe takes effect one edge after the clock on which it is low, and reset acts without waiting for an edge. The bench applies every nibble on a falling edge and samples on the falling edge that follows the counted number of rising edges, so each check sees a value that has settled for half a clock.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  // Nibble width is fixed by the bus protocol.
  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] START_NIB = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_NIB  = 4'b0000;
  localparam logic [NIB_W-1:0] ONES_NIB  = 4'b1111;
  // Cycle type bits 3:1 for a memory read; bit 0 is don't-care.
  localparam logic [2:0]       MEM_RD_TYPE = 3'b010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_HTAR,
    ST_TTAR,
    ST_SYNC,
    ST_DATA,
    ST_TOUT,
    ST_REL
  } tgtState_e;

  typedef enum logic [1:0] {
    DRV_OFF,
    DRV_ONES,
    DRV_SYNC,
    DRV_DATA
  } drvSel_e;

  typedef struct packed {
    logic    shiftAddr;
    logic    capData;
    logic    shiftData;
    drvSel_e drv;
  } tgtCtl_t;

endpackage

// File: rtl/lpc_tgt_ctrl.sv
module lpc_tgt_ctrl
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic [NIB_W-1:0] ladIn,
  output tgtCtl_t          ctl,
  output logic             memRdEn
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W     = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  tgtState_e        state, nextState;
  logic [CNT_W-1:0] nibCnt, nextCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nibCnt <= '0;
    end else begin
      state  <= nextState;
      nibCnt <= nextCnt;
    end
  end

  always_comb begin
    nextState = state;
    nextCnt   = nibCnt;
    if (!frameN) begin
      // A low strobe always wins: restart or drop to idle.
      nextState = (ladIn == START_NIB) ? ST_CTYPE : ST_IDLE;
      nextCnt   = '0;
    end else begin
      unique case (state)
        ST_IDLE:  nextState = ST_IDLE;
        ST_CTYPE: begin
          nextCnt   = '0;
          nextState = (ladIn[3:1] == MEM_RD_TYPE) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          if (nibCnt == ADDR_LAST) begin
            nextState = ST_HTAR;
            nextCnt   = '0;
          end else begin
            nextCnt = nibCnt + 1'b1;
          end
        end
        ST_HTAR:  nextState = ST_TTAR;
        ST_TTAR:  nextState = ST_SYNC;
        ST_SYNC: begin
          nextState = ST_DATA;
          nextCnt   = '0;
        end
        ST_DATA: begin
          if (nibCnt == DATA_LAST) begin
            nextState = ST_TOUT;
            nextCnt   = '0;
          end else begin
            nextCnt = nibCnt + 1'b1;
          end
        end
        ST_TOUT:  nextState = ST_REL;
        ST_REL:   nextState = ST_IDLE;
        default:  nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.shiftAddr = frameN && (state == ST_ADDR);
    ctl.capData   = frameN && (state == ST_TTAR);
    ctl.shiftData = frameN && (state == ST_DATA);
    unique case (state)
      ST_TTAR, ST_TOUT: ctl.drv = DRV_ONES;
      ST_SYNC:          ctl.drv = DRV_SYNC;
      ST_DATA:          ctl.drv = DRV_DATA;
      default:          ctl.drv = DRV_OFF;
    endcase
  end

  assign memRdEn = (state == ST_HTAR);

endmodule

// File: rtl/lpc_tgt_dpath.sv
module lpc_tgt_dpath
  import lpc_tgt_pkg::*;
#(
  parameter int MEM_AW = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtCtl_t           ctl,
  input  logic [NIB_W-1:0]  ladIn,
  input  logic [DATA_W-1:0] memData,
  output logic [MEM_AW-1:0] memAddr,
  output logic [NIB_W-1:0]  ladOut,
  output logic              ladOe
);

  logic [MEM_AW-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  // Upper address nibbles fall off the top as the low ones arrive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctl.shiftAddr) begin
      addrReg <= {addrReg[MEM_AW-NIB_W-1:0], ladIn};
    end
  end

  // Byte captured whole, then shifted so the low nibble leaves first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (ctl.capData) begin
      dataReg <= memData;
    end else if (ctl.shiftData) begin
      dataReg <= {{NIB_W{1'b0}}, dataReg[DATA_W-1:NIB_W]};
    end
  end

  always_comb begin
    unique case (ctl.drv)
      DRV_SYNC: ladOut = SYNC_NIB;
      DRV_DATA: ladOut = dataReg[NIB_W-1:0];
      default:  ladOut = ONES_NIB;
    endcase
  end

  assign ladOe   = (ctl.drv != DRV_OFF);
  assign memAddr = addrReg;

endmodule

// File: rtl/lpc_read_target.sv
module lpc_read_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MEM_AW = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [DATA_W-1:0] memData
);

  tgtCtl_t ctl;

  lpc_tgt_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .ladIn  (ladIn),
    .ctl    (ctl),
    .memRdEn(memRdEn)
  );

  lpc_tgt_dpath #(
    .MEM_AW(MEM_AW),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .ladIn  (ladIn),
    .memData(memData),
    .memAddr(memAddr),
    .ladOut (ladOut),
    .ladOe  (ladOe)
  );

endmodule

// File: rtl/lpc_read_target_chk.sv
module lpc_read_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameN,
  input logic [3:0] ladOut,
  input logic       ladOe,
  input logic       memRdEn
);

  // R12 / R1: bus released while reset is held.
  assert_released_in_reset_R12: assert property (@(posedge clk)
    !rstN |-> (!ladOe && !memRdEn));

  // R5: an uncancelled array read is followed by the all-ones drive.
  assert_turnaround_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && frameN) |=> (ladOe && ladOut == 4'hF));

  // R6: the second driven clock of a burst carries the sync value.
  assert_sync_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ladOe && $past(ladOe) && !$past(ladOe, 2)) |-> (ladOut == 4'h0));

  // R8: a release not caused by the strobe comes right after all ones.
  assert_release_after_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ladOe) && $past(frameN)) |-> ($past(ladOut) == 4'hF));

  // R11: a low strobe never leaves the bus driven on the next clock.
  assert_cancel_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !ladOe);

endmodule

bind lpc_read_target lpc_read_target_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .frameN (frameN),
  .ladOut (ladOut),
  .ladOe  (ladOe),
  .memRdEn(memRdEn)
);

// File: tb/lpc_read_target_test.sv
module lpc_read_target_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameN;
  logic [3:0]  ladIn;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic        memRdEn;
  logic [18:0] memAddr;
  logic [7:0]  memData;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lpc_read_target uut (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .ladIn  (ladIn),
    .ladOut (ladOut),
    .ladOe  (ladOe),
    .memRdEn(memRdEn),
    .memAddr(memAddr),
    .memData(memData)
  );

  function automatic logic [7:0] memFn(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  // Synchronous byte array model: one clock from request to data.
  always_ff @(posedge clk) begin
    if (memRdEn) memData <= memFn(memAddr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start, cycle type, eight address nibbles, host turnaround nibble.
  task automatic sendHeader(input logic [3:0] startNib, input logic [3:0] cyc, input logic [31:0] addr);
    @(negedge clk); frameN = 1'b0; ladIn = startNib;
    @(negedge clk); frameN = 1'b1; ladIn = cyc;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); ladIn = addr[i*4 +: 4];
    end
    @(negedge clk); ladIn = 4'hF;
  endtask

  task automatic expectData(input logic [31:0] addr, input string tag);
    logic [7:0] exp;
    exp = memFn(addr[18:0]);
    chk(memRdEn && memAddr == addr[18:0], {"R4 ", tag}, {12'b0, memRdEn, memAddr}, {13'h1, addr[18:0]});
    @(negedge clk);
    chk(ladOe && ladOut == 4'hF, {"R5 ", tag}, {ladOe, ladOut}, 5'h1F);
    @(negedge clk);
    chk(ladOe && ladOut == 4'h0, {"R6 ", tag}, {ladOe, ladOut}, 5'h10);
    @(negedge clk);
    chk(ladOe && ladOut == exp[3:0], {"R7 low ", tag}, {ladOe, ladOut}, {1'b1, exp[3:0]});
    @(negedge clk);
    chk(ladOe && ladOut == exp[7:4], {"R7 high ", tag}, {ladOe, ladOut}, {1'b1, exp[7:4]});
    @(negedge clk);
    chk(ladOe && ladOut == 4'hF, {"R8 ones ", tag}, {ladOe, ladOut}, 5'h1F);
    @(negedge clk);
    chk(!ladOe, {"R8 release ", tag}, ladOe, 0);
    @(negedge clk);
    chk(!ladOe, {"R10 idle ", tag}, ladOe, 0);
  endtask

  task automatic expectSilent(input int n, input string req);
    int seen = 0;
    if (memRdEn) seen++;
    repeat (n) begin
      @(negedge clk);
      if (ladOe || memRdEn) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic testReset;
    rstN = 1'b0; frameN = 1'b1; ladIn = 4'hF;
    repeat (3) @(negedge clk);
    chk(!ladOe && !memRdEn, "R1 in reset", {ladOe, memRdEn}, 0);
    rstN = 1'b1;
    expectSilent(3, "R1 after reset");
  endtask

  task automatic testReads;
    sendHeader(4'h0, 4'b0100, 32'h000ABCDE); expectData(32'h000ABCDE, "basic");
    sendHeader(4'h0, 4'b0101, 32'h00012345); expectData(32'h00012345, "R3 bit0 set");
    sendHeader(4'h0, 4'b0100, 32'hFFF81234); expectData(32'hFFF81234, "high bits");
    sendHeader(4'h0, 4'b0100, 32'h0007FFFF); expectData(32'h0007FFFF, "top byte");
  endtask

  task automatic testBadType;
    sendHeader(4'h0, 4'b0110, 32'h00001111); expectSilent(8, "R9 write type");
    sendHeader(4'h0, 4'b1100, 32'h00002222); expectSilent(8, "R9 type 1100");
    sendHeader(4'h0, 4'b0000, 32'h00003333); expectSilent(8, "R3 type 0000");
  endtask

  task automatic testStart;
    sendHeader(4'h2, 4'b0100, 32'h00004444); expectSilent(8, "R9 bad start");
    // Several low clocks, last one is zero: accepted.
    @(negedge clk); frameN = 1'b0; ladIn = 4'h5;
    @(negedge clk); ladIn = 4'h3;
    sendHeader(4'h0, 4'b0100, 32'h00055555); expectData(32'h00055555, "R2 last zero");
    // Several low clocks, last one is not zero: ignored.
    @(negedge clk); frameN = 1'b0; ladIn = 4'h0;
    sendHeader(4'hA, 4'b0100, 32'h00066666); expectSilent(8, "R2 last nonzero");
  endtask

  task automatic testAbort;
    // Cancelled during the address, restarted at once.
    @(negedge clk); frameN = 1'b0; ladIn = 4'h0;
    @(negedge clk); frameN = 1'b1; ladIn = 4'b0100;
    repeat (3) begin @(negedge clk); ladIn = 4'h7; end
    sendHeader(4'h0, 4'b0100, 32'h00077777); expectData(32'h00077777, "R11 restart");
    // Cancelled during the sync clock with a non-start nibble.
    sendHeader(4'h0, 4'b0100, 32'h00011111);
    @(negedge clk);
    @(negedge clk); frameN = 1'b0; ladIn = 4'h9;
    @(negedge clk); frameN = 1'b1; ladIn = 4'hF;
    chk(!ladOe, "R11 cancel in sync", ladOe, 0);
    expectSilent(6, "R11 stays idle");
  endtask

  task automatic testResetMid;
    sendHeader(4'h0, 4'b0100, 32'h00022222);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(!ladOe, "R12 reset mid cycle", ladOe, 0);
    @(negedge clk); rstN = 1'b1;
    expectSilent(4, "R12 idle after reset");
    sendHeader(4'h0, 4'b0100, 32'h00033333); expectData(32'h00033333, "R12 read after reset");
  endtask

  initial begin
    testReset();
    testReads();
    testBadType();
    testStart();
    testAbort();
    testResetMid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule